// File: doc/BRIEF.md
# Key Auto-Repeat Generator

This block turns a vector of already-clean button levels into press events with typematic behaviour. The levels are looked at only on a poll strobe, typically one strobe per video frame. A button that a poll sees pressed for the first time produces one event. If the button is still held, the block stays silent for an initial delay measured in polls. After that it produces an event every repeat period, for as long as the button stays held.

Every button has its own small state machine and counter, so buttons never affect one another. A menu or cursor controller downstream sees one single-clock pulse per event. These pulses appear on the clock after the strobe, one bit per button. The initial delay and the repeat period are parameters, with defaults of 30 polls and 6 polls.

Top module: `key_repeat_gen`

## Requirements
- R1: While reset is high, and on the first clock after it, `key_events` is all zero. Every button leaves reset in the released state, so a button held through reset gets a first-press event on the first poll after reset.
- R2: A bit of `key_events` can be 1 only on the clock that directly follows a clock edge where `poll_stb` was 1. It is zero on every other cycle, and each pulse lasts exactly one clock.
- R3: When a poll sees button k pressed (`keys_raw[k]` = 1) and the previous poll saw it released, or no poll has occurred since reset, `key_events[k]` is 1 on the following clock.
- R4: A poll that sees button k released (`keys_raw[k]` = 0) never produces an event on bit k.
- R5: While a button stays held, the polls numbered 1 to FIRST_DELAY-1 after its first-press poll produce no event for it.
- R6: A button held continuously produces an event on poll number FIRST_DELAY after its first-press poll.
- R7: After that event the button produces an event every REPEAT_EVERY polls, and at no other poll, for as long as it is held. An arbitrarily long hold never produces a false first-press event.
- R8: A release seen by a single poll is enough to restart the sequence. The next pressed poll gives a first-press event, and the initial delay counts again from that poll.
- R9: Each button's event timing depends only on its own bit of `keys_raw`. Buttons pressed at different polls, or together, keep separate schedules.
- R10: Changes of `keys_raw` between strobes have no effect. A press and release that both fall between two polls produce no event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| poll_stb | input | 1 | One-clock strobe; the button levels are sampled on the edge where it is high |
| keys_raw | input | NUM_KEYS | Button levels, 1 = pressed, already debounced and synchronous to clk |
| key_events | output | NUM_KEYS | Registered press/repeat events, one clock wide, on the clock after a strobe |

## Verification
The properties assume that `keys_raw` is synchronous to `clk` and stable at the strobe edge. They also assume that `poll_stb` is low while reset is high, so that no poll ever mixes with reset. The bench drives every input on the falling edge. It raises the strobe only after reset has been released. It changes button levels only between strobes, apart from the deliberate glitch used for the R10 check. The early-repeat property keeps its own count of held polls for each button, saturating at the delay, rather than looking back a parameter-sized number of cycles.

// File: rtl/key_repeat_pkg.sv
package key_repeat_pkg;

  // Per-button hold phase
  typedef enum logic [1:0] {
    PH_RELEASED = 2'd0,
    PH_INITIAL  = 2'd1,
    PH_REPEAT   = 2'd2
  } hold_phase_e;

  // Bits needed to hold a count 0 .. max(a,b)-1
  function automatic int span_bits(input int a, input int b);
    int m;
    m = (a > b) ? a : b;
    return (m < 2) ? 1 : $clog2(m);
  endfunction

endpackage

// File: rtl/key_hold_slot.sv
module key_hold_slot
  import key_repeat_pkg::*;
#(
  parameter int FIRST_DELAY  = 30,
  parameter int REPEAT_EVERY = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic poll,
  input  logic pressed,
  output logic fire
);

  localparam int CW = span_bits(FIRST_DELAY, REPEAT_EVERY);
  localparam logic [CW-1:0] DELAY_LAST  = CW'(FIRST_DELAY - 1);
  localparam logic [CW-1:0] PERIOD_LAST = CW'(REPEAT_EVERY - 1);

  hold_phase_e     phase_q, phase_d;
  logic [CW-1:0]   cnt_q, cnt_d;

  // Next-state and fire decision for one poll
  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    fire    = 1'b0;
    if (poll) begin
      if (!pressed) begin
        phase_d = PH_RELEASED;
        cnt_d   = '0;
      end else begin
        unique case (phase_q)
          PH_RELEASED: begin
            phase_d = PH_INITIAL;
            cnt_d   = '0;
            fire    = 1'b1;
          end
          PH_INITIAL: begin
            if (cnt_q == DELAY_LAST) begin
              phase_d = PH_REPEAT;
              cnt_d   = '0;
              fire    = 1'b1;
            end else begin
              cnt_d = cnt_q + 1'b1;
            end
          end
          PH_REPEAT: begin
            if (cnt_q == PERIOD_LAST) begin
              cnt_d = '0;
              fire  = 1'b1;
            end else begin
              cnt_d = cnt_q + 1'b1;
            end
          end
          default: begin
            phase_d = PH_RELEASED;
            cnt_d   = '0;
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_RELEASED;
      cnt_q   <= '0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
    end
  end

endmodule

// File: rtl/key_event_reg.sv
module key_event_reg #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             poll,
  input  logic [WIDTH-1:0] fire,
  output logic [WIDTH-1:0] events
);

  always_ff @(posedge clk) begin
    if (rst) begin
      events <= '0;
    end else if (poll) begin
      events <= fire;
    end else begin
      events <= '0;
    end
  end

endmodule

// File: rtl/key_repeat_gen.sv
module key_repeat_gen #(
  parameter int NUM_KEYS     = 4,
  parameter int FIRST_DELAY  = 30,
  parameter int REPEAT_EVERY = 6
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                poll_stb,
  input  logic [NUM_KEYS-1:0] keys_raw,
  output logic [NUM_KEYS-1:0] key_events
);

  logic [NUM_KEYS-1:0] fire_vec;

  for (genvar k = 0; k < NUM_KEYS; k++) begin : g_slot
    key_hold_slot #(
      .FIRST_DELAY  (FIRST_DELAY),
      .REPEAT_EVERY (REPEAT_EVERY)
    ) u_slot (
      .clk     (clk),
      .rst     (rst),
      .poll    (poll_stb),
      .pressed (keys_raw[k]),
      .fire    (fire_vec[k])
    );
  end

  key_event_reg #(
    .WIDTH (NUM_KEYS)
  ) u_evreg (
    .clk    (clk),
    .rst    (rst),
    .poll   (poll_stb),
    .fire   (fire_vec),
    .events (key_events)
  );

endmodule

// File: rtl/key_repeat_gen_chk.sv
module key_repeat_gen_chk #(
  parameter int NUM_KEYS     = 4,
  parameter int FIRST_DELAY  = 30,
  parameter int REPEAT_EVERY = 6
) (
  input logic                clk,
  input logic                rst,
  input logic                poll_stb,
  input logic [NUM_KEYS-1:0] keys_raw,
  input logic [NUM_KEYS-1:0] key_events
);

  localparam int HW = (FIRST_DELAY < 1) ? 1 : $clog2(FIRST_DELAY + 1);
  localparam logic [HW-1:0] HOLD_SAT = HW'(FIRST_DELAY);

  logic [NUM_KEYS-1:0] seen_q;
  logic [HW-1:0]       hold_q [NUM_KEYS];

  // Levels seen at the last poll and held-poll count, saturating at the delay
  always_ff @(posedge clk) begin
    if (rst) begin
      seen_q <= '0;
      for (int k = 0; k < NUM_KEYS; k++) hold_q[k] <= '0;
    end else if (poll_stb) begin
      seen_q <= keys_raw;
      for (int k = 0; k < NUM_KEYS; k++) begin
        if (keys_raw[k] && seen_q[k]) begin
          if (hold_q[k] != HOLD_SAT) hold_q[k] <= hold_q[k] + 1'b1;
        end else begin
          hold_q[k] <= '0;
        end
      end
    end
  end

  AST_QUIET_OFF_POLL: assert property (@(posedge clk) disable iff (rst)
    (key_events != '0) |-> $past(poll_stb && !rst)); // R2

  AST_EVENT_NEEDS_PRESS: assert property (@(posedge clk) disable iff (rst)
    (key_events != '0) |-> ((key_events & ~$past(keys_raw)) == '0)); // R4

  for (genvar k = 0; k < NUM_KEYS; k++) begin : g_key_props
    AST_FIRST_PRESS: assert property (@(posedge clk) disable iff (rst)
      (poll_stb && keys_raw[k] && !seen_q[k]) |=> key_events[k]); // R3

    AST_NO_EARLY_REPEAT: assert property (@(posedge clk) disable iff (rst)
      (key_events[k] && hold_q[k] != '0) |-> (hold_q[k] == HOLD_SAT)); // R5
  end

endmodule

bind key_repeat_gen key_repeat_gen_chk #(
  .NUM_KEYS     (NUM_KEYS),
  .FIRST_DELAY  (FIRST_DELAY),
  .REPEAT_EVERY (REPEAT_EVERY)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .poll_stb   (poll_stb),
  .keys_raw   (keys_raw),
  .key_events (key_events)
);

// File: tb/key_repeat_gen_bench.sv
`timescale 1ns/1ps
module key_repeat_gen_bench;

  localparam int N = 4;
  localparam int D = 30;
  localparam int P = 6;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         poll = 1'b0;
  logic [N-1:0] keys = '0;
  logic [N-1:0] ev;

  typedef struct {
    logic [N-1:0] vec;
    string        tag;
  } exp_t;

  exp_t  sbq[$];
  int    n_cmp = 0;
  int    n_bad = 0;
  int    hold[N];
  string cur_tag = "R3";
  logic  mon_poll = 1'b0;
  bit    done = 1'b0;

  always #10 clk = ~clk;

  key_repeat_gen #(
    .NUM_KEYS     (N),
    .FIRST_DELAY  (D),
    .REPEAT_EVERY (P)
  ) u_key_repeat_gen (
    .clk        (clk),
    .rst        (rst),
    .poll_stb   (poll),
    .keys_raw   (keys),
    .key_events (ev)
  );

  task automatic check(string tag, logic [N-1:0] got, logic [N-1:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s at %0t: actual=%b expected=%b", tag, $time, got, exp);
    end
  endtask

  // Driver: model the poll from the requirements, push expectation, strobe
  task automatic do_poll(int idle);
    exp_t it;
    @(negedge clk);
    it.vec = '0;
    it.tag = cur_tag;
    for (int k = 0; k < N; k++) begin
      if (keys[k]) hold[k]++;
      else hold[k] = -1;
      if (hold[k] == 0) it.vec[k] = 1'b1;                                   // R3
      else if (hold[k] >= D && ((hold[k] - D) % P) == 0) it.vec[k] = 1'b1;  // R6 R7
    end
    sbq.push_back(it);
    poll = 1'b1;
    @(negedge clk);
    poll = 1'b0;
    repeat (idle) @(negedge clk);
  endtask

  // Monitor
  always @(posedge clk) mon_poll <= poll && !rst;

  always @(negedge clk) begin
    if (!rst && !done) begin
      if (mon_poll) begin
        if (sbq.size() == 0) begin
          n_cmp++;
          n_bad++;
          $display("FAIL R2: actual=unexpected poll result expected=empty scoreboard");
        end else begin
          exp_t it;
          it = sbq.pop_front();
          check(it.tag, ev, it.vec);
        end
      end else begin
        check("R2", ev, '0);   // quiet between strobes
      end
    end
  end

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      if (sbq.size() != 0) begin
        n_cmp++;
        n_bad++;
        $display("FAIL R2: actual=%0d pending expected=0 pending", sbq.size());
      end
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL R2 watchdog: actual=still running expected=finished");
    finish_up();
  end

  initial begin
    for (int k = 0; k < N; k++) hold[k] = -1;
    keys = 4'b0001;                       // key0 held through reset (R1)
    repeat (4) @(negedge clk);
    check("R1", ev, '0);
    rst = 1'b0;
    @(negedge clk);
    check("R1", ev, '0);

    // R1 R3: first poll after reset sees key0 pressed
    cur_tag = "R1 R3";
    do_poll(1);

    // R5 R6: key0 held through the delay
    cur_tag = "R5 R6";
    for (int i = 0; i < 40; i++) do_poll(i % 3);

    // R9: key1 joins, key2 later, schedules stay separate
    cur_tag = "R9";
    keys[1] = 1'b1;
    for (int i = 0; i < 7; i++) do_poll(1);
    keys[2] = 1'b1;
    for (int i = 0; i < 20; i++) do_poll(i % 2);

    // R4 R8: key0 released for one poll, re-pressed, delay restarts
    cur_tag = "R4 R8";
    keys[0] = 1'b0;
    do_poll(2);
    keys[0] = 1'b1;
    for (int i = 0; i < 38; i++) do_poll(i % 3);
    keys[2] = 1'b0;
    for (int i = 0; i < 3; i++) do_poll(0);

    // R10: key3 pulses between polls and is never seen
    cur_tag = "R10";
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      keys[3] = 1'b1;
      @(negedge clk);
      keys[3] = 1'b0;
      do_poll(1);
    end

    // R7: key1 held for a long run, repeats keep their period
    cur_tag = "R7";
    keys[0] = 1'b0;
    for (int i = 0; i < 220; i++) do_poll(i % 2);

    // R8 R9: all released then pressed together
    cur_tag = "R8 R9";
    keys = '0;
    do_poll(1);
    keys = '1;
    for (int i = 0; i < 45; i++) do_poll(1);

    repeat (4) @(negedge clk);
    finish_up();
  end

endmodule